// File: doc/BRIEF.md
# Register Write-Pending Hazard Scoreboard

The scoreboard holds one pending bit for every architectural register. A set bit means that a write to that register is still outstanding. Function-unit slots raise set requests when they issue an instruction. Write-back ports and the completion interface of each slot raise clear requests. From the pending vector and the register numbers being checked, the block computes two hazard flags. The first is a per-slot read-after-write flag for the source operands a slot is waiting on. The second is a write-after-write flag for the destination of the instruction about to issue.

A set request is held in a register for one clock before it reaches the vector. This keeps an instruction that reads and writes the same register from stalling on itself. Sometimes an instruction that was issued with a destination write flag completes with its data-valid flag low. In that case the slot clears the bit itself, because no write-back will ever arrive for it. The issue logic reads both hazard flags. It supplies register numbers either as binary numbers with an enable or as one-hot masks, and a parameter chooses which form is used.

Top module: `hzd_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, so no hazard flag is raised after reset until a new set request has been applied.
- R2: A slot that asserts issue with its write flag high sets the pending bit of its destination exactly two rising edges after the issue cycle. The bit is not yet set after the first edge.
- R3: During its own issue cycle, an instruction whose source equals its destination sees no read hazard from its own set request.
- R4: A write-back port with its enable high clears the pending bit of its register number at the next rising edge.
- R5: A slot latches its write flag at issue. If the slot later reports done with that latch set and data-valid low, the pending bit of its destination is cleared at that edge.
- R6: A slot's latched write flag is dropped at the first edge where busy is low without an issue. A later done with data-valid low then clears nothing.
- R7: Set requests from all slots, and clear requests from all write-back ports and all slots, are OR-combined before they are applied, so simultaneous requests on different ports all take effect.
- R8: A slot's read hazard is high exactly when an enabled source register of that slot has its pending bit set and checking has not been switched off (R9).
- R9: Once a slot has seen busy high with no read hazard at an edge, its operand check mask is forced to zero, and its read hazard stays low until an edge where busy is low.
- R10: The write-after-write flag is high exactly when the check enable is high and the checked destination register's pending bit is set. The vector used is the one from before any set request of the same instruction.
- R11: When a set and a clear target the same bit at the same edge, the clear wins and the bit ends low.
- R12: A set request to a bit that is already pending leaves it pending.
- R13: With ENC = binary (value 0, the default), register fields are binary numbers of clog2(NUM_REGS) bits decoded as 1 << n. With ENC = one-hot (value 1), fields are NUM_REGS-bit masks used as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| slot_issue_i | input | NUM_SLOTS | Issue strobe per slot |
| slot_wr_flag_i | input | NUM_SLOTS | Destination write flag per slot, valid with issue |
| slot_dest_i | input | NUM_SLOTS x FIELD_W | Destination register per slot, held while the slot is busy |
| slot_busy_i | input | NUM_SLOTS | Slot busy |
| slot_done_i | input | NUM_SLOTS | Slot completion strobe |
| slot_data_ok_i | input | NUM_SLOTS | Destination data valid at completion |
| slot_src_en_i | input | NUM_SLOTS x NUM_SRC | Source operand enables |
| slot_src_i | input | NUM_SLOTS x NUM_SRC x FIELD_W | Source operand registers |
| wb_en_i | input | NUM_WB | Write-back port enable |
| wb_reg_i | input | NUM_WB x FIELD_W | Write-back register |
| chk_dest_en_i | input | 1 | Enable for the incoming destination check |
| chk_dest_i | input | FIELD_W | Incoming instruction destination register |
| raw_o | output | NUM_SLOTS | Read-after-write hazard per slot |
| waw_o | output | 1 | Write-after-write hazard for the incoming destination |

## Verification
Both hazard outputs are combinational from the current pending vector and the present inputs. The bench therefore samples them in the same cycle the inputs are driven, half a cycle after the edge. A write-back clear or a no-data completion shows in the vector after one edge. An issue-time set shows only after two edges. The bench reads the whole vector between edges by sweeping the destination-check input over every register, and it compares the result against a reference model that is advanced at each rising edge. Directed sequences sample at one edge and at two edges after the stimulus to pin down the delay of each path.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Form in which register numbers arrive on every field of the block
    typedef enum logic {
        REG_ENC_BINARY = 1'b0,
        REG_ENC_ONEHOT = 1'b1
    } reg_enc_e;

    // Control bundle of one function-unit slot
    typedef struct packed {
        logic issue;
        logic wr_flag;
        logic busy;
        logic done;
        logic data_ok;
    } slot_ctl_t;

    function automatic int field_width(int nregs, reg_enc_e enc);
        if (enc == REG_ENC_ONEHOT) return nregs;
        return (nregs > 1) ? $clog2(nregs) : 1;
    endfunction

endpackage

// File: rtl/hzd_reg_decode.sv
module hzd_reg_decode
    import hzd_pkg::*;
#(
    parameter int       NUM_REGS = 32,
    parameter reg_enc_e ENC      = REG_ENC_BINARY,
    parameter int       FIELD_W  = field_width(NUM_REGS, ENC)
) (
    input  logic                en_i,
    input  logic [FIELD_W-1:0]  field_i,
    output logic [NUM_REGS-1:0] mask_o
);

    localparam logic [NUM_REGS-1:0] BIT0 = NUM_REGS'(1);

    generate
        if (ENC == REG_ENC_ONEHOT) begin : g_onehot
            assign mask_o = en_i ? NUM_REGS'(field_i) : '0;
        end else begin : g_binary
            assign mask_o = en_i ? (BIT0 << field_i) : '0;
        end
    endgenerate

endmodule

// File: rtl/hzd_pending_vec.sv
module hzd_pending_vec #(
    parameter int NUM_REGS = 32,
    parameter int NUM_SET  = 2,
    parameter int NUM_CLR  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_SET-1:0][NUM_REGS-1:0]  set_i,
    input  logic [NUM_CLR-1:0][NUM_REGS-1:0]  clr_i,
    output logic [NUM_REGS-1:0]               pend_o
);

    logic [NUM_REGS-1:0] pend_q;
    logic [NUM_REGS-1:0] set_any;
    logic [NUM_REGS-1:0] clr_any;

    always_comb begin
        set_any = '0;
        for (int s = 0; s < NUM_SET; s++) set_any |= set_i[s];
        clr_any = '0;
        for (int c = 0; c < NUM_CLR; c++) clr_any |= clr_i[c];
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | set_any) & ~clr_any;
    end

    assign pend_o = pend_q;

    // R1
    rst_clr_chk: assert property (@(posedge clk) rst |=> pend_q == '0);

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_any != '0) |=> (pend_q & $past(clr_any)) == '0);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q != '0) |=> (($past(pend_q) & ~$past(clr_any)) & ~pend_q) == '0);

    // R7
    set_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (set_any != '0) |=> (($past(set_any) & ~$past(clr_any)) & ~pend_q) == '0);

endmodule

// File: rtl/hzd_slot_track.sv
module hzd_slot_track
    import hzd_pkg::*;
#(
    parameter int       NUM_REGS = 32,
    parameter int       NUM_SRC  = 2,
    parameter reg_enc_e ENC      = REG_ENC_BINARY,
    parameter int       FIELD_W  = field_width(NUM_REGS, ENC)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  slot_ctl_t                        ctl_i,
    input  logic [FIELD_W-1:0]               dest_i,
    input  logic [NUM_SRC-1:0]               src_en_i,
    input  logic [NUM_SRC-1:0][FIELD_W-1:0]  src_i,
    input  logic [NUM_REGS-1:0]              pend_i,
    output logic [NUM_REGS-1:0]              set_o,
    output logic [NUM_REGS-1:0]              clr_o,
    output logic                             raw_o
);

    logic [NUM_REGS-1:0]              dest_mask;
    logic [NUM_SRC-1:0][NUM_REGS-1:0] src_mask;
    logic [NUM_REGS-1:0]              src_any;
    logic [NUM_REGS-1:0]              chk_mask;
    logic [NUM_REGS-1:0]              set_q;
    logic                             wr_lat_q;
    logic                             pass_q;

    hzd_reg_decode #(.NUM_REGS(NUM_REGS), .ENC(ENC), .FIELD_W(FIELD_W)) u_dest (
        .en_i   (1'b1),
        .field_i(dest_i),
        .mask_o (dest_mask)
    );

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
            hzd_reg_decode #(.NUM_REGS(NUM_REGS), .ENC(ENC), .FIELD_W(FIELD_W)) u_src (
                .en_i   (src_en_i[k]),
                .field_i(src_i[k]),
                .mask_o (src_mask[k])
            );
        end
    endgenerate

    always_comb begin
        src_any = '0;
        for (int k = 0; k < NUM_SRC; k++) src_any |= src_mask[k];
    end

    // operand checking is switched off once the slot has cleared its hazards
    assign chk_mask = pass_q ? '0 : src_any;
    assign raw_o    = |(pend_i & chk_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q    <= '0;
            wr_lat_q <= 1'b0;
            pass_q   <= 1'b0;
        end else begin
            set_q <= (ctl_i.issue && ctl_i.wr_flag) ? dest_mask : '0;
            if (ctl_i.issue)      wr_lat_q <= ctl_i.wr_flag;
            else if (!ctl_i.busy) wr_lat_q <= 1'b0;
            if (!ctl_i.busy)      pass_q <= 1'b0;
            else if (!raw_o)      pass_q <= 1'b1;
        end
    end

    assign set_o = set_q;
    assign clr_o = (ctl_i.done && wr_lat_q && !ctl_i.data_ok) ? dest_mask : '0;

    // R2
    set_late_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl_i.issue && ctl_i.wr_flag) |=> set_o == '0);

    // R6
    lat_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.busy && !ctl_i.issue) |=> clr_o == '0);

    // R9
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.busy && !raw_o) |=> !raw_o);

    // R5
    nodata_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.issue && ctl_i.wr_flag) ##1 (ctl_i.done && !ctl_i.data_ok)
        |-> clr_o == dest_mask);

endmodule

// File: rtl/hzd_scoreboard.sv
module hzd_scoreboard
    import hzd_pkg::*;
#(
    parameter int       NUM_REGS  = 32,
    parameter int       NUM_SLOTS = 2,
    parameter int       NUM_SRC   = 2,
    parameter int       NUM_WB    = 2,
    parameter reg_enc_e ENC       = REG_ENC_BINARY,
    parameter int       FIELD_W   = field_width(NUM_REGS, ENC)
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [NUM_SLOTS-1:0]                           slot_issue_i,
    input  logic [NUM_SLOTS-1:0]                           slot_wr_flag_i,
    input  logic [NUM_SLOTS-1:0][FIELD_W-1:0]              slot_dest_i,
    input  logic [NUM_SLOTS-1:0]                           slot_busy_i,
    input  logic [NUM_SLOTS-1:0]                           slot_done_i,
    input  logic [NUM_SLOTS-1:0]                           slot_data_ok_i,
    input  logic [NUM_SLOTS-1:0][NUM_SRC-1:0]              slot_src_en_i,
    input  logic [NUM_SLOTS-1:0][NUM_SRC-1:0][FIELD_W-1:0] slot_src_i,
    input  logic [NUM_WB-1:0]                              wb_en_i,
    input  logic [NUM_WB-1:0][FIELD_W-1:0]                 wb_reg_i,
    input  logic                                           chk_dest_en_i,
    input  logic [FIELD_W-1:0]                             chk_dest_i,
    output logic [NUM_SLOTS-1:0]                           raw_o,
    output logic                                           waw_o
);

    localparam int NUM_CLR = NUM_WB + NUM_SLOTS;

    logic [NUM_REGS-1:0]                 pend;
    logic [NUM_SLOTS-1:0][NUM_REGS-1:0]  set_req;
    logic [NUM_CLR-1:0][NUM_REGS-1:0]    clr_req;
    logic [NUM_REGS-1:0]                 chk_mask;

    generate
        for (genvar w = 0; w < NUM_WB; w++) begin : g_wb
            hzd_reg_decode #(.NUM_REGS(NUM_REGS), .ENC(ENC), .FIELD_W(FIELD_W)) u_wb (
                .en_i   (wb_en_i[w]),
                .field_i(wb_reg_i[w]),
                .mask_o (clr_req[w])
            );
        end

        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            slot_ctl_t ctl;
            assign ctl = '{issue:   slot_issue_i[s],
                           wr_flag: slot_wr_flag_i[s],
                           busy:    slot_busy_i[s],
                           done:    slot_done_i[s],
                           data_ok: slot_data_ok_i[s]};

            hzd_slot_track #(
                .NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC), .ENC(ENC), .FIELD_W(FIELD_W)
            ) u_track (
                .clk     (clk),
                .rst     (rst),
                .ctl_i   (ctl),
                .dest_i  (slot_dest_i[s]),
                .src_en_i(slot_src_en_i[s]),
                .src_i   (slot_src_i[s]),
                .pend_i  (pend),
                .set_o   (set_req[s]),
                .clr_o   (clr_req[NUM_WB+s]),
                .raw_o   (raw_o[s])
            );
        end
    endgenerate

    hzd_pending_vec #(.NUM_REGS(NUM_REGS), .NUM_SET(NUM_SLOTS), .NUM_CLR(NUM_CLR)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_req),
        .clr_i (clr_req),
        .pend_o(pend)
    );

    hzd_reg_decode #(.NUM_REGS(NUM_REGS), .ENC(ENC), .FIELD_W(FIELD_W)) u_chk (
        .en_i   (chk_dest_en_i),
        .field_i(chk_dest_i),
        .mask_o (chk_mask)
    );

    assign waw_o = |(pend & chk_mask);

    // R10
    waw_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_dest_en_i |-> !waw_o);

    // R4
    wb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en_i[0] && chk_dest_en_i && chk_dest_i == wb_reg_i[0]
         && $stable(chk_dest_i)) |=> (!waw_o || !$stable(chk_dest_i)));

endmodule

// File: tb/tb_hzd_scoreboard.sv
`timescale 1ns/1ps
module tb_hzd_scoreboard;

    localparam int NR = 32;
    localparam int NS = 2;
    localparam int NK = 2;
    localparam int NW = 2;
    localparam int FW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NS-1:0] issue, wrf, busy, done, dok;
    logic [NS-1:0][FW-1:0] dest;
    logic [NS-1:0][NK-1:0] sen;
    logic [NS-1:0][NK-1:0][FW-1:0] src;
    logic [NW-1:0] wben;
    logic [NW-1:0][FW-1:0] wbreg;
    logic chk_en;
    logic [FW-1:0] chk_dest;
    logic [NS-1:0] raw_o;
    logic waw_o;

    int checks = 0;
    int fails = 0;

    // reference model state
    logic [NR-1:0] m_pend;
    logic [NR-1:0] m_setq [NS];
    logic m_lat [NS];
    logic m_pass [NS];

    always #2 clk = ~clk;

    hzd_scoreboard dut (
        .clk(clk), .rst(rst),
        .slot_issue_i(issue), .slot_wr_flag_i(wrf), .slot_dest_i(dest),
        .slot_busy_i(busy), .slot_done_i(done), .slot_data_ok_i(dok),
        .slot_src_en_i(sen), .slot_src_i(src),
        .wb_en_i(wben), .wb_reg_i(wbreg),
        .chk_dest_en_i(chk_en), .chk_dest_i(chk_dest),
        .raw_o(raw_o), .waw_o(waw_o)
    );

    function automatic logic [NR-1:0] oh(logic [FW-1:0] n);
        return NR'(1) << n;
    endfunction

    function automatic logic exp_raw(int s);
        logic [NR-1:0] m = '0;
        for (int k = 0; k < NK; k++) if (sen[s][k]) m |= oh(src[s][k]);
        if (m_pass[s]) m = '0;
        return |(m_pend & m);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic read_vec(output logic [NR-1:0] v);
        logic [FW-1:0] keep = chk_dest;
        logic keep_en = chk_en;
        chk_en = 1'b1;
        for (int r = 0; r < NR; r++) begin
            chk_dest = FW'(r);
            #0.01;
            v[r] = waw_o;
        end
        chk_dest = keep;
        chk_en = keep_en;
        #0.01;
    endtask

    task automatic idle();
        issue = '0; wrf = '0; busy = '0; done = '0; dok = '0;
        dest = '0; sen = '0; src = '0; wben = '0; wbreg = '0;
        chk_en = 1'b0; chk_dest = '0;
    endtask

    // advance one rising edge and the model with it; returns 1 ns after the edge
    task automatic step();
        logic [NR-1:0] setv, clrv;
        logic r [NS];
        @(posedge clk);
        setv = '0; clrv = '0;
        for (int s = 0; s < NS; s++) begin
            r[s] = exp_raw(s);
            setv |= m_setq[s];
            if (done[s] && m_lat[s] && !dok[s]) clrv |= oh(dest[s]);
        end
        for (int w = 0; w < NW; w++) if (wben[w]) clrv |= oh(wbreg[w]);
        if (rst) begin
            m_pend = '0;
            for (int s = 0; s < NS; s++) begin
                m_setq[s] = '0; m_lat[s] = 1'b0; m_pass[s] = 1'b0;
            end
        end else begin
            m_pend = (m_pend | setv) & ~clrv;
            for (int s = 0; s < NS; s++) begin
                m_setq[s] = (issue[s] && wrf[s]) ? oh(dest[s]) : '0;
                if (issue[s]) m_lat[s] = wrf[s];
                else if (!busy[s]) m_lat[s] = 1'b0;
                if (!busy[s]) m_pass[s] = 1'b0;
                else if (!r[s]) m_pass[s] = 1'b1;
            end
        end
        #1;
    endtask

    task automatic compare_all();
        logic [NR-1:0] v;
        #0.5;
        for (int s = 0; s < NS; s++)
            check(raw_o[s] == exp_raw(s), "R8 raw vs model", 32'(raw_o[s]), 32'(exp_raw(s)));
        check(waw_o == (chk_en && m_pend[chk_dest]), "R10 waw vs model",
              32'(waw_o), 32'(chk_en && m_pend[chk_dest]));
        read_vec(v);
        check(v == m_pend, "R7 pending vector vs model", v, m_pend);
    endtask

    task automatic expect_bit(int r, logic e, string tag);
        logic save_en = chk_en;
        logic [FW-1:0] save_d = chk_dest;
        chk_en = 1'b1; chk_dest = FW'(r);
        #0.01;
        check(waw_o == e, tag, 32'(waw_o), 32'(e));
        chk_en = save_en; chk_dest = save_d;
        #0.01;
    endtask

    function automatic logic [FW-1:0] rreg();
        return ($urandom_range(0, 3) == 0) ? FW'($urandom_range(0, NR-1))
                                           : FW'($urandom_range(0, 7));
    endfunction

    initial begin
        #(4.0 * 200000);
        check(1'b0, "watchdog", 32'(checks), 32'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NR-1:0] v;
        void'($urandom(32'd4242));
        idle();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;

        // R1: nothing pending after reset
        read_vec(v);
        check(v == '0, "R1 vector after reset", v, 32'h0);
        check(raw_o == '0 && waw_o == 1'b0, "R1 flags after reset", 32'(raw_o), 32'h0);

        // R3/R10: issue writes r5 and reads r5 in the same cycle
        issue[0] = 1; wrf[0] = 1; dest[0] = 5; sen[0][0] = 1; src[0][0] = 5;
        chk_en = 1; chk_dest = 5;
        #0.5;
        check(raw_o[0] == 1'b0, "R3 no self hazard", 32'(raw_o[0]), 32'h0);
        check(waw_o == 1'b0, "R10 waw uses vector before own set", 32'(waw_o), 32'h0);
        step();
        idle();
        busy[0] = 1;
        expect_bit(5, 1'b0, "R2 not set after first edge");
        step();
        expect_bit(5, 1'b1, "R2 set after second edge");
        sen[1][0] = 1; src[1][0] = 5;
        #0.2;
        check(raw_o[1] == 1'b1, "R8 read hazard on pending r5", 32'(raw_o[1]), 32'h1);
        chk_en = 1; chk_dest = 5;
        #0.2;
        check(waw_o == 1'b1, "R10 waw on pending r5", 32'(waw_o), 32'h1);

        // R12: set again while pending
        idle();
        issue[1] = 1; wrf[1] = 1; dest[1] = 5;
        step(); idle(); step();
        expect_bit(5, 1'b1, "R12 stays pending");

        // R11: set and clear of r9 meet at one edge
        issue[0] = 1; wrf[0] = 1; dest[0] = 9;
        step(); idle();
        wben[0] = 1; wbreg[0] = 9;
        step(); idle();
        expect_bit(9, 1'b0, "R11 clear wins");

        // R4: write-back clears r5
        wben[1] = 1; wbreg[1] = 5;
        step(); idle();
        expect_bit(5, 1'b0, "R4 write-back clear");

        // R7: two sets, then two clears, in one cycle each
        issue = 2'b11; wrf = 2'b11; dest[0] = 3; dest[1] = 4;
        step(); idle(); step();
        read_vec(v);
        check(v == 32'h18, "R7 two sets", v, 32'h18);
        wben = 2'b11; wbreg[0] = 3; wbreg[1] = 4;
        step(); idle();
        read_vec(v);
        check(v == 32'h0, "R7 two clears", v, 32'h0);

        // R5: completion without data clears r12
        issue[0] = 1; wrf[0] = 1; dest[0] = 12;
        step(); idle();
        busy[0] = 1; dest[0] = 12;
        step();
        expect_bit(12, 1'b1, "R5 pending before completion");
        done[0] = 1; dok[0] = 0;
        step(); idle();
        expect_bit(12, 1'b0, "R5 no-data completion clears");

        // R6: latch dropped once slot idle, later no-data done clears nothing
        issue[1] = 1; wrf[1] = 1; dest[1] = 13;
        step(); idle();
        dest[1] = 13;
        step();
        done[1] = 1; dok[1] = 0;
        step(); idle();
        expect_bit(13, 1'b1, "R6 latch dropped, bit kept");
        wben[0] = 1; wbreg[0] = 13;
        step(); idle();

        // R9: check mask forced off after a hazard-free busy edge
        issue[1] = 1; wrf[1] = 1; dest[1] = 20;
        step(); idle(); step();
        busy[0] = 1; sen[0][0] = 1; src[0][0] = 21;
        #0.2;
        check(raw_o[0] == 1'b0, "R9 no hazard on r21", 32'(raw_o[0]), 32'h0);
        step();
        src[0][0] = 20;
        #0.2;
        check(raw_o[0] == 1'b0, "R9 mask off while busy", 32'(raw_o[0]), 32'h0);
        busy[0] = 0;
        step();
        #0.2;
        check(raw_o[0] == 1'b1, "R9 checking resumes after idle", 32'(raw_o[0]), 32'h1);
        idle();
        wben[0] = 1; wbreg[0] = 20;
        step(); idle();

        // R13: binary field 31 addresses the top bit
        issue[0] = 1; wrf[0] = 1; dest[0] = 31;
        step(); idle(); step();
        read_vec(v);
        check(v == 32'h8000_0000, "R13 binary decode of 31", v, 32'h8000_0000);

        // random phase against the model
        for (int cyc = 0; cyc < 3000; cyc++) begin
            for (int s = 0; s < NS; s++) begin
                issue[s] = ($urandom_range(0, 3) == 0);
                wrf[s]   = ($urandom_range(0, 3) != 0);
                dest[s]  = rreg();
                busy[s]  = ($urandom_range(0, 2) != 0);
                done[s]  = ($urandom_range(0, 4) == 0);
                dok[s]   = $urandom_range(0, 1);
                for (int k = 0; k < NK; k++) begin
                    sen[s][k] = $urandom_range(0, 1);
                    src[s][k] = rreg();
                end
            end
            for (int w = 0; w < NW; w++) begin
                wben[w] = ($urandom_range(0, 2) == 0);
                wbreg[w] = rreg();
            end
            chk_en = $urandom_range(0, 1);
            chk_dest = rreg();
            compare_all();
            step();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule